// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Interrupts

This block is a memory-mapped general-purpose I/O controller for 64 or 96 pins. Pins are organised in banks of 32, and every 32-bit register word covers one bank. For each pin the host can read the synchronised input level and choose the pin's direction. It drives the output latch through separate write-one-to-set and write-one-to-clear words, so no read-modify-write is needed. It can also enable detection of rising edges, falling edges or both. A detected edge is kept in a sticky status bit until the host writes a one to that bit. Every pin also has a 2-bit alternate function selector, and one level interrupt goes to the host.

The host uses a simple register bus. An access is taken in the cycle where the select input is high. Writes take effect at that clock edge. Read data is combinational, from the same address, in the same cycle. Registers sit in eight feature groups that follow one another from address zero. Each group is as wide as the number of banks, so its stride grows with the pin count. The alternate function group holds two words per bank.

Top module: `gpio_ctl`

## Requirements
- R1: The word index is the byte address divided by 4. Feature group g, bank b sits at word index g×NBANK+b, where NBANK = NUM_PINS/32. The group order is: level g=0, direction g=1, set g=2, clear g=3, rising enable g=4, falling enable g=5, edge status g=6, alternate function g=7. Accesses with a nonzero address [1:0], and addresses past the last alternate function word, read zero and change nothing. Writes to the level group change nothing.
- R2: Reading the level group returns the pin inputs after a two-flop synchroniser. A pin change applied before clock edge k can be read after edge k+1, and not after edge k.
- R3: A direction bit of 1 makes the pin an output (pin_oe high). A bit of 0 makes it an input. The direction word reads back as written.
- R4: Writing the set word sets the output latch bits where the data is 1. Writing the clear word clears them. Zero data bits leave the latch unchanged. pin_out shows the latch, and both words read back as the latch.
- R5: A rising-enable bit records a 0→1 change of the synchronised pin, and a falling-enable bit records a 1→0 change. The two are independent, and with both set either edge is recorded. The status bit is set at the edge after the change becomes readable in the level group, that is, after edge k+2.
- R6: Status bits are sticky. Writing the status word clears the bits where the data is 1. Zero bits have no effect, and writing all ones clears the whole bank.
- R7: If an edge event and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R8: The alternate function field of pin p is 2 bits, in word p/16 of group 7 (word index 7×NBANK + p/16), at bits (p mod 16)×2+1:(p mod 16)×2. It drives pin_alt[2p+1:2p] and reads back as written.
- R9: irq is high exactly while at least one status bit is set in any bank.
- R10: After reset the direction, output latch, both enable groups, status and alternate function registers are all zero, and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| pin_in | input | NUM_PINS | Asynchronous pin inputs |
| pin_out | output | NUM_PINS | Output latch |
| pin_oe | output | NUM_PINS | Output enable (direction) |
| pin_alt | output | 2×NUM_PINS | Alternate function selectors |
| irq | output | 1 | Level interrupt, OR of all status bits |

## Verification
Register writes are visible at the ports and in read data right after the clock edge that takes them. A pin change is readable after two edges, and its status bit and irq after three. The bench changes pins and bus signals on the falling edge and waits exactly that many rising edges before sampling. It also samples one edge early to show that the level is not yet visible. The same-cycle collision of an event and a clear is set up by starting the clearing write on the falling edge just before the edge at which the event is captured.

// File: rtl/gpio_ctl_pkg.sv
// Shared definitions for the banked GPIO controller.
// Assumes 32-bit register words, one bank of pins per word.
package gpio_ctl_pkg;
    localparam int unsigned BANK_W = 32;

    // Feature groups in address order
    typedef enum logic [2:0] {
        GRP_LEVEL = 3'd0,
        GRP_DIR   = 3'd1,
        GRP_SET   = 3'd2,
        GRP_CLR   = 3'd3,
        GRP_RISE  = 3'd4,
        GRP_FALL  = 3'd5,
        GRP_STS   = 3'd6,
        GRP_ALT   = 3'd7
    } grp_e;

    // Per-bank write strobes
    typedef struct packed {
        logic dir;
        logic set;
        logic clr;
        logic rise;
        logic fall;
        logic sts;
    } bank_we_t;
endpackage

// File: rtl/gpio_ctl_sync.sv
// Synchroniser for one bank of asynchronous pin inputs. It gives the
// synchronised level and the level one cycle earlier for edge detection.
// Assumes the inputs are asynchronous to clk; STAGES >= 2.
module gpio_ctl_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] lvl_prev
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            // Shift the input through the synchroniser chain
            always_ff @(posedge clk) begin
                if (!rst_n)  stage_q[s] <= '0;
                else if (s == 0) stage_q[s] <= din;
                else         stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign lvl = stage_q[STAGES-1];

    // Hold the previous synchronised sample for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_prev <= '0;
        else        lvl_prev <= lvl;
    end
endmodule

// File: rtl/gpio_ctl_bank.sv
// Register set for one 32-pin bank: direction, output latch, edge
// enables and sticky edge status. Assumes set and clear strobes are
// never active together (they are different addresses).
module gpio_ctl_bank
    import gpio_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  bank_we_t          we,
    input  logic [BANK_W-1:0] wdata,
    input  logic [BANK_W-1:0] lvl,
    input  logic [BANK_W-1:0] lvl_prev,
    output logic [BANK_W-1:0] dir_q,
    output logic [BANK_W-1:0] out_q,
    output logic [BANK_W-1:0] rise_q,
    output logic [BANK_W-1:0] fall_q,
    output logic [BANK_W-1:0] sts_q
);
    logic [BANK_W-1:0] evt;

    // Enabled edges on the synchronised level
    assign evt = (lvl & ~lvl_prev & rise_q) | (~lvl & lvl_prev & fall_q);

    // Configuration registers: direction and edge enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= '0;
            rise_q <= '0;
            fall_q <= '0;
        end else begin
            if (we.dir)  dir_q  <= wdata;
            if (we.rise) rise_q <= wdata;
            if (we.fall) fall_q <= wdata;
        end
    end

    // Output latch with write-one set and write-one clear
    always_ff @(posedge clk) begin
        if (!rst_n)      out_q <= '0;
        else if (we.set) out_q <= out_q | wdata;
        else if (we.clr) out_q <= out_q & ~wdata;
    end

    // Sticky status: clearing write first, then new events win
    always_ff @(posedge clk) begin
        if (!rst_n) sts_q <= '0;
        else        sts_q <= (sts_q & ~(we.sts ? wdata : '0)) | evt;
    end

    // R4: set bits land in the latch
    p_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        we.set |=> ((out_q & $past(wdata)) == $past(wdata)));
    // R4: clear bits leave the latch low
    p_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        we.clr |=> ((out_q & $past(wdata)) == '0));
    // R6: without a clearing write no status bit falls
    p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !we.sts |=> ((sts_q & $past(sts_q)) == $past(sts_q)));
    // R7: an event is never lost, even against a clear
    p_evt_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((sts_q & $past(evt)) == $past(evt)));
endmodule

// File: rtl/gpio_ctl.sv
// Banked GPIO controller top. It decodes the feature-group address map,
// holds the alternate function words, muxes read data and drives the
// interrupt. Assumes NUM_PINS is a multiple of 32 and that ADDR_W covers
// 9*NUM_PINS/32 words. Reads are combinational; writes take effect at
// the clock edge where bus_sel and bus_wr are high.
module gpio_ctl
    import gpio_ctl_pkg::*;
#(
    parameter int unsigned NUM_PINS = 64,
    parameter int unsigned ADDR_W   = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic [NUM_PINS-1:0]   pin_in,
    output logic [NUM_PINS-1:0]   pin_out,
    output logic [NUM_PINS-1:0]   pin_oe,
    output logic [2*NUM_PINS-1:0] pin_alt,
    output logic                  irq
);
    localparam int unsigned NBANK     = NUM_PINS / BANK_W;
    localparam int unsigned ALT_WORDS = 2 * NBANK;
    localparam int unsigned WORD_W    = ADDR_W - 2;
    localparam int unsigned ALT_BASE  = int'(GRP_ALT) * NBANK;

    logic [WORD_W-1:0] word;
    logic              aligned;
    logic              wr_en;

    logic [BANK_W-1:0] lvl_w  [NBANK];
    logic [BANK_W-1:0] prev_w [NBANK];
    logic [BANK_W-1:0] dir_w  [NBANK];
    logic [BANK_W-1:0] out_w  [NBANK];
    logic [BANK_W-1:0] rise_w [NBANK];
    logic [BANK_W-1:0] fall_w [NBANK];
    logic [BANK_W-1:0] sts_w  [NBANK];
    logic [NBANK-1:0]  sts_any;
    logic [31:0]       alt_q  [ALT_WORDS];

    assign word    = bus_addr[ADDR_W-1:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign wr_en   = bus_sel && bus_wr && aligned;

    genvar b, w;
    generate
        for (b = 0; b < NBANK; b++) begin : g_bank
            bank_we_t we_b;

            // Decode this bank's write strobes from the group map
            always_comb begin
                we_b.dir  = wr_en && (word == WORD_W'(int'(GRP_DIR)  * NBANK + b));
                we_b.set  = wr_en && (word == WORD_W'(int'(GRP_SET)  * NBANK + b));
                we_b.clr  = wr_en && (word == WORD_W'(int'(GRP_CLR)  * NBANK + b));
                we_b.rise = wr_en && (word == WORD_W'(int'(GRP_RISE) * NBANK + b));
                we_b.fall = wr_en && (word == WORD_W'(int'(GRP_FALL) * NBANK + b));
                we_b.sts  = wr_en && (word == WORD_W'(int'(GRP_STS)  * NBANK + b));
            end

            gpio_ctl_sync #(.WIDTH(BANK_W), .STAGES(2)) u_sync (
                .clk      (clk),
                .rst_n    (rst_n),
                .din      (pin_in[BANK_W*b +: BANK_W]),
                .lvl      (lvl_w[b]),
                .lvl_prev (prev_w[b])
            );

            gpio_ctl_bank u_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .we       (we_b),
                .wdata    (bus_wdata),
                .lvl      (lvl_w[b]),
                .lvl_prev (prev_w[b]),
                .dir_q    (dir_w[b]),
                .out_q    (out_w[b]),
                .rise_q   (rise_w[b]),
                .fall_q   (fall_w[b]),
                .sts_q    (sts_w[b])
            );

            assign pin_out[BANK_W*b +: BANK_W] = out_w[b];
            assign pin_oe[BANK_W*b +: BANK_W]  = dir_w[b];
            assign sts_any[b]                  = |sts_w[b];
        end

        for (w = 0; w < ALT_WORDS; w++) begin : g_alt
            // Alternate function word: 16 two-bit fields
            always_ff @(posedge clk) begin
                if (!rst_n) alt_q[w] <= '0;
                else if (wr_en && (word == WORD_W'(ALT_BASE + w))) alt_q[w] <= bus_wdata;
            end
            assign pin_alt[32*w +: 32] = alt_q[w];

            // R8: a written alternate function word appears on pin_alt
            p_alt_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && (word == WORD_W'(ALT_BASE + w)))
                    |=> (pin_alt[32*w +: 32] == $past(bus_wdata)));
        end
    endgenerate

    // Interrupt: any sticky status bit in any bank
    assign irq = |sts_any;

    // Read mux over the group map; unmapped or misaligned reads give zero
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && aligned) begin
            for (int i = 0; i < int'(NBANK); i++) begin
                if (word == WORD_W'(int'(GRP_LEVEL) * NBANK + i)) bus_rdata = lvl_w[i];
                if (word == WORD_W'(int'(GRP_DIR)   * NBANK + i)) bus_rdata = dir_w[i];
                if (word == WORD_W'(int'(GRP_SET)   * NBANK + i)) bus_rdata = out_w[i];
                if (word == WORD_W'(int'(GRP_CLR)   * NBANK + i)) bus_rdata = out_w[i];
                if (word == WORD_W'(int'(GRP_RISE)  * NBANK + i)) bus_rdata = rise_w[i];
                if (word == WORD_W'(int'(GRP_FALL)  * NBANK + i)) bus_rdata = fall_w[i];
                if (word == WORD_W'(int'(GRP_STS)   * NBANK + i)) bus_rdata = sts_w[i];
            end
            for (int j = 0; j < int'(ALT_WORDS); j++) begin
                if (word == WORD_W'(ALT_BASE + j)) bus_rdata = alt_q[j];
            end
        end
    end

    // R9: irq cannot rise without an enabled edge recorded in status
    p_irq_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (sts_any != '0));
    // R1: a misaligned write changes no alternate function word
    p_misaligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && !aligned) |=> $stable(pin_alt));
endmodule

// File: tb/gpio_ctl_tb.sv
`timescale 1ns/1ps
module gpio_ctl_tb;
    localparam int NP = 64;
    localparam int NB = NP / 32;

    logic            clk = 0;
    logic            rst_n = 0;
    logic            bus_sel = 0, bus_wr = 0;
    logic [7:0]      bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NP-1:0]   pin_in = '0;
    logic [NP-1:0]   pin_out, pin_oe;
    logic [2*NP-1:0] pin_alt;
    logic            irq;

    int checks = 0, fails = 0;
    bit done = 0;

    gpio_ctl #(.NUM_PINS(NP), .ADDR_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .pin_alt(pin_alt), .irq(irq)
    );

    always #4 clk = ~clk;

    // Byte address of group g, bank b
    function automatic logic [7:0] ga(int g, int b);
        return 8'((g * NB + b) * 4);
    endfunction
    // Byte address of alternate function word w
    function automatic logic [7:0] aa(int w);
        return 8'((7 * NB + w) * 4);
    endfunction
    // Expected new status bits for a pin change
    function automatic logic [31:0] edges(logic [31:0] o, logic [31:0] n,
                                          logic [31:0] r, logic [31:0] f);
        return (n & ~o & r) | (~n & o & f);
    endfunction

    task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called just after a falling edge; returns just after the next one
    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask
    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 0;
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] exp_out [NB];
        logic [31:0] exp_sts [NB];
        logic [NP-1:0] old_pins;
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R10: reset state
        for (int g = 0; g < 7; g++)
            for (int b = 0; b < NB; b++) begin
                rd(ga(g, b), d); chk("R10 reset reg", d, 0);
            end
        for (int w = 0; w < 2 * NB; w++) begin rd(aa(w), d); chk("R10 reset alt", d, 0); end
        chk("R10 pin_oe", pin_oe, 0);
        chk("R10 pin_out", pin_out, 0);
        chk("R10 irq", irq, 0);

        // R3: direction
        wr(ga(1, 1), 32'hA5A5_0F0F);
        chk("R3 pin_oe", pin_oe, {32'hA5A5_0F0F, 32'h0});
        rd(ga(1, 1), d); chk("R3 readback", d, 32'hA5A5_0F0F);

        // R4: set/clear, directed then random
        for (int b = 0; b < NB; b++) exp_out[b] = 0;
        wr(ga(2, 0), 32'hFFFF_0000); exp_out[0] = 32'hFFFF_0000;
        wr(ga(3, 0), 32'h0000_0000);
        chk("R4 zero clear no effect", pin_out[31:0], exp_out[0]);
        for (int i = 0; i < 30; i++) begin
            int b = $urandom_range(NB - 1);
            logic [31:0] m = $urandom;
            if ($urandom_range(1)) begin wr(ga(2, b), m); exp_out[b] |= m; end
            else begin wr(ga(3, b), m); exp_out[b] &= ~m; end
            chk("R4 pin_out", pin_out[32*b +: 32], exp_out[b]);
            rd(ga(3, b), d); chk("R4 readback", d, exp_out[b]);
        end

        // R1: level group is read-only, misaligned and unmapped read zero
        wr(ga(0, 0), 32'hFFFF_FFFF);
        rd(ga(0, 0), d); chk("R1 level write ignored", d, 0);
        rd(8'd72, d); chk("R1 unmapped", d, 0);
        rd(8'd252, d); chk("R1 unmapped top", d, 0);
        rd(ga(1, 1) + 8'd1, d); chk("R1 misaligned read", d, 0);
        wr(aa(0) + 8'd2, 32'hFFFF_FFFF);
        chk("R1 misaligned write", pin_alt, 0);

        // R2: level after two edges, not after one
        pin_in = 64'h1234_5678_9ABC_DEF0;
        @(negedge clk);
        rd(ga(0, 0), d); chk("R2 not yet", d, 0);
        @(negedge clk);
        rd(ga(0, 0), d); chk("R2 level b0", d, 32'h9ABC_DEF0);
        rd(ga(0, 1), d); chk("R2 level b1", d, 32'h1234_5678);
        @(negedge clk);
        old_pins = pin_in;

        // R5/R6/R9: random edges with random enables
        for (int b = 0; b < NB; b++) exp_sts[b] = 0;
        for (int i = 0; i < 40; i++) begin
            logic [NP-1:0] np;
            logic [31:0] r [NB];
            logic [31:0] f [NB];
            for (int b = 0; b < NB; b++) begin
                r[b] = $urandom; f[b] = $urandom;
                if (i % 5 == 0) begin r[b] = '1; f[b] = '1; end
                wr(ga(4, b), r[b]); wr(ga(5, b), f[b]);
            end
            np = {$urandom, $urandom};
            pin_in = np;
            repeat (3) @(negedge clk);
            for (int b = 0; b < NB; b++) begin
                exp_sts[b] |= edges(old_pins[32*b +: 32], np[32*b +: 32], r[b], f[b]);
                rd(ga(6, b), d); chk("R5 status", d, exp_sts[b]);
            end
            chk("R9 irq", irq, (exp_sts[0] != 0) || (exp_sts[1] != 0));
            old_pins = np;
            if ($urandom_range(2) == 0) begin
                int b = $urandom_range(NB - 1);
                logic [31:0] m = $urandom;
                wr(ga(6, b), m); exp_sts[b] &= ~m;
                rd(ga(6, b), d); chk("R6 partial clear", d, exp_sts[b]);
            end
        end
        // R6: zero write has no effect, all ones clears the bank
        wr(ga(6, 0), 32'h0);
        rd(ga(6, 0), d); chk("R6 zero write", d, exp_sts[0]);
        for (int b = 0; b < NB; b++) begin
            wr(ga(6, b), '1);
            rd(ga(6, b), d); chk("R6 clear all", d, 0);
        end
        chk("R9 irq low", irq, 0);

        // R5: both enables on one pin catch rise then fall
        wr(ga(4, 0), 32'h1); wr(ga(5, 0), 32'h1);
        pin_in[0] = 1'b0; repeat (3) @(negedge clk); wr(ga(6, 0), '1);
        pin_in[0] = 1'b1; repeat (3) @(negedge clk);
        rd(ga(6, 0), d); chk("R5 rise", d, 32'h1);
        wr(ga(6, 0), '1);
        pin_in[0] = 1'b0; repeat (3) @(negedge clk);
        rd(ga(6, 0), d); chk("R5 fall", d, 32'h1);
        wr(ga(6, 0), '1);

        // R7: clear and event in the same cycle; event wins
        pin_in[0] = 1'b1;
        repeat (2) @(negedge clk);
        wr(ga(6, 0), 32'h1);
        rd(ga(6, 0), d); chk("R7 event wins", d, 32'h1);
        chk("R7 irq", irq, 1);
        wr(ga(6, 0), '1);

        // R8: alternate function fields
        wr(aa(1), 32'h0000_0200);
        chk("R8 pin20 field", pin_alt[41:40], 2'd2);
        chk("R8 pin_alt word1", pin_alt[63:32], 32'h0000_0200);
        wr(aa(3), 32'hC000_0001);
        chk("R8 pin48 field", pin_alt[97:96], 2'd1);
        chk("R8 pin63 field", pin_alt[127:126], 2'd3);
        rd(aa(3), d); chk("R8 readback", d, 32'hC000_0001);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule